// File: doc/BRIEF.md
# Host-to-Firmware Write Mailbox

This block carries one message of up to eight bytes from an external host processor to on-chip firmware. The host writes the message one 32-bit word at a time. Its write to the upper word commits the message. The commit marks the mailbox full and raises an interrupt toward firmware. Firmware reads both words through its own read port and then clears the interrupt. That clear posts a sticky empty event back to the host, which tells the host it may send the next message.

While the mailbox is full, it refuses every host write, so a committed message cannot be torn. An upper-word write that arrives while the mailbox is full is dropped and recorded in a sticky overrun flag. The host clears the empty event and the overrun flag by writing 1 to the matching bit of its event-clear input. The meaning of the message is left to software.

Top module: `host_fw_mailbox`

## Requirements
- R1: Out of reset both message words read 0, the firmware interrupt fw_full_irq_o is 0, the host empty event host_empty_evt_o is 1, and the overrun flag host_ovr_o is 0.
- R2: A host write with host_wr_sel_i = 0 while the mailbox is not full stores the data in the lower word. Firmware reads the lower word with fw_rd_addr_i = 0 and the upper word with fw_rd_addr_i = 1. The read is combinational.
- R3: A host write with host_wr_sel_i = 1 while the mailbox is not full stores the data in the upper word and sets fw_full_irq_o from the next cycle.
- R4: A host write to the lower word alone never sets fw_full_irq_o.
- R5: A pulse on fw_full_clr_i while fw_full_irq_o is 1 clears fw_full_irq_o and sets host_empty_evt_o from the next cycle.
- R6: host_empty_evt_o stays set until the host writes 1 to host_evt_clr_i[0]. If a set and that clear fall in the same cycle, the set wins.
- R7: While fw_full_irq_o is 1, host writes to either word leave the stored message unchanged. An upper-word write in that state sets host_ovr_o from the next cycle.
- R8: host_ovr_o stays set until the host writes 1 to host_evt_clr_i[1].
- R9: A pulse on fw_full_clr_i while the mailbox is not full leaves host_empty_evt_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_en_i | input | 1 | Host word write strobe |
| host_wr_sel_i | input | 1 | Word select: 0 selects the lower word, 1 the upper word (commit) |
| host_wr_data_i | input | 32 | Host write data |
| host_evt_clr_i | input | 2 | Write-1-to-clear: bit 0 clears the empty event, bit 1 clears overrun |
| fw_rd_addr_i | input | 1 | Firmware word select for reads |
| fw_rd_data_o | output | 32 | Firmware read data |
| fw_full_clr_i | input | 1 | Firmware clears the full interrupt |
| fw_full_irq_o | output | 1 | Mailbox full interrupt to firmware |
| host_empty_evt_o | output | 1 | Sticky mailbox-empty event to host |
| host_ovr_o | output | 1 | Sticky overrun flag to host |

## Verification
A full state that goes wrong shows at the ports within one cycle. A missed commit leaves fw_full_irq_o low after the upper-word write. A spurious full state makes the next host write vanish from fw_rd_data_o. A storage word that changes while the mailbox is full shows on the very next combinational firmware read. Errors in the empty event or the overrun flag show on the cycle after the set, clear or conflicting stimulus, because both flags are registered directly onto their outputs.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_WORD_W    = 32;
  localparam int unsigned MBOX_NUM_WORDS = 2;
  localparam int unsigned EVT_W          = 2;

  typedef enum logic [0:0] {
    EVT_EMPTY = 1'b0,
    EVT_OVR   = 1'b1
  } evt_bit_e;
endpackage

// File: rtl/mbox_sticky.sv
module mbox_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;   // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 2,
  localparam int unsigned ADDR_W   = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] word_q [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     word_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i))     word_q[i] <= wr_data_i;
    end

    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == ADDR_W'(i)) |=> $stable(word_q[i]));
  end

  assign rd_data_o = word_q[rd_addr_i];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
  parameter int unsigned NUM_WORDS = 2,
  localparam int unsigned ADDR_W   = $clog2(NUM_WORDS),
  localparam logic [ADDR_W-1:0] COMMIT_ADDR = ADDR_W'(NUM_WORDS - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_sel_i,
  input  logic              fw_clr_i,
  output logic              store_we_o,
  output logic              full_o,
  output logic              empty_set_o,
  output logic              ovr_set_o
);
  logic is_commit;

  assign is_commit   = wr_en_i && (wr_sel_i == COMMIT_ADDR);
  assign store_we_o  = wr_en_i && !full_o;
  assign ovr_set_o   = is_commit && full_o;
  assign empty_set_o = fw_clr_i && full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   full_o <= 1'b0;
    else if (empty_set_o)          full_o <= 1'b0;
    else if (is_commit && !full_o) full_o <= 1'b1;
  end

  p_commit_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_commit && !full_o) |=> full_o);
  p_low_no_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_o && !is_commit) |=> !full_o);
  p_clr_drops_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && fw_clr_i) |=> !full_o);
endmodule

// File: rtl/host_fw_mailbox.sv
module host_fw_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned WORD_W    = MBOX_WORD_W,
  parameter int unsigned NUM_WORDS = MBOX_NUM_WORDS,
  localparam int unsigned ADDR_W   = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_en_i,
  input  logic [ADDR_W-1:0] host_wr_sel_i,
  input  logic [WORD_W-1:0] host_wr_data_i,
  input  logic [EVT_W-1:0]  host_evt_clr_i,
  input  logic [ADDR_W-1:0] fw_rd_addr_i,
  output logic [WORD_W-1:0] fw_rd_data_o,
  input  logic              fw_full_clr_i,
  output logic              fw_full_irq_o,
  output logic              host_empty_evt_o,
  output logic              host_ovr_o
);
  logic store_we, empty_set, ovr_set;

  mbox_ctrl #(.NUM_WORDS(NUM_WORDS)) i_ctrl (
    .clk_i, .rst_ni,
    .wr_en_i     (host_wr_en_i),
    .wr_sel_i    (host_wr_sel_i),
    .fw_clr_i    (fw_full_clr_i),
    .store_we_o  (store_we),
    .full_o      (fw_full_irq_o),
    .empty_set_o (empty_set),
    .ovr_set_o   (ovr_set)
  );

  mbox_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_store (
    .clk_i, .rst_ni,
    .wr_en_i   (store_we),
    .wr_addr_i (host_wr_sel_i),
    .wr_data_i (host_wr_data_i),
    .rd_addr_i (fw_rd_addr_i),
    .rd_data_o (fw_rd_data_o)
  );

  mbox_sticky #(.RST_VAL(1'b1)) i_empty (
    .clk_i, .rst_ni,
    .set_i (empty_set),
    .clr_i (host_evt_clr_i[EVT_EMPTY]),
    .q_o   (host_empty_evt_o)
  );

  mbox_sticky #(.RST_VAL(1'b0)) i_ovr (
    .clk_i, .rst_ni,
    .set_i (ovr_set),
    .clr_i (host_evt_clr_i[EVT_OVR]),
    .q_o   (host_ovr_o)
  );

  p_empty_on_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_full_irq_o && fw_full_clr_i) |=> host_empty_evt_o);
  p_ovr_on_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_full_irq_o && host_wr_en_i && host_wr_sel_i == ADDR_W'(NUM_WORDS - 1)) |=> host_ovr_o);
  p_idle_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fw_full_irq_o && !host_empty_evt_o) |=> !host_empty_evt_o);
endmodule

// File: tb/test_host_fw_mailbox.sv
module test_host_fw_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  evt_clr = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        full_clr = 1'b0;
  logic        full_irq, empty_evt, ovr;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  host_fw_mailbox i_host_fw_mailbox (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_en_i(wr_en), .host_wr_sel_i(wr_sel), .host_wr_data_i(wr_data),
    .host_evt_clr_i(evt_clr), .fw_rd_addr_i(rd_addr), .fw_rd_data_o(rd_data),
    .fw_full_clr_i(full_clr), .fw_full_irq_o(full_irq),
    .host_empty_evt_o(empty_evt), .host_ovr_o(ovr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  // one-cycle stimulus, returns at the following negedge
  task automatic cyc(logic we, logic sel, logic [31:0] d, logic [1:0] ec, logic fc);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; evt_clr = ec; full_clr = fc;
    @(negedge clk);
    wr_en = 0; evt_clr = '0; full_clr = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); chk("R1 word0", d, 0);
    rd(1, d); chk("R1 word1", d, 0);
    chk("R1 full", full_irq, 0);
    chk("R1 empty", empty_evt, 1);
    chk("R1 ovr", ovr, 0);
  endtask

  task automatic t_low_write;
    logic [31:0] d;
    cyc(1, 0, 32'hA5A5_0001, 0, 0);
    rd(0, d); chk("R2 low stored", d, 32'hA5A5_0001);
    rd(1, d); chk("R2 high untouched", d, 0);
    chk("R4 no full on low", full_irq, 0);
  endtask

  task automatic t_commit;
    logic [31:0] d;
    cyc(1, 1, 32'hB0B0_0002, 0, 0);
    chk("R3 full set", full_irq, 1);
    rd(1, d); chk("R3 high stored", d, 32'hB0B0_0002);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    cyc(1, 1, 32'hDEAD_0003, 0, 0);
    chk("R7 ovr set", ovr, 1);
    rd(1, d); chk("R7 high kept", d, 32'hB0B0_0002);
    cyc(1, 0, 32'hDEAD_0004, 0, 0);
    rd(0, d); chk("R7 low kept", d, 32'hA5A5_0001);
    chk("R8 ovr sticky", ovr, 1);
  endtask

  task automatic t_fw_clear;
    cyc(0, 0, 0, 2'b01, 0);
    chk("R6 empty cleared by host", empty_evt, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R5 full cleared", full_irq, 0);
    chk("R5 empty set", empty_evt, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R6 empty sticky", empty_evt, 1);
  endtask

  task automatic t_host_clears;
    cyc(0, 0, 0, 2'b10, 0);
    chk("R8 ovr cleared", ovr, 0);
    chk("R6 empty kept by ovr clr", empty_evt, 1);
    cyc(0, 0, 0, 2'b01, 0);
    chk("R6 empty cleared", empty_evt, 0);
  endtask

  task automatic t_idle_clear;
    cyc(0, 0, 0, 0, 1);
    chk("R9 empty unchanged", empty_evt, 0);
    chk("R9 full unchanged", full_irq, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    cyc(1, 1, 32'h1234_5678, 0, 0);
    rd(1, d); chk("R3 second message", d, 32'h1234_5678);
    cyc(0, 0, 0, 2'b01, 1);
    chk("R6 set beats clear", empty_evt, 1);
    chk("R5 full cleared again", full_irq, 0);
  endtask

  initial begin
    #20000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low_write();
    t_commit();
    t_overrun();
    t_fw_clear();
    t_host_clears();
    t_idle_clear();
    t_set_wins();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule